// File: doc/BRIEF.md
# Transmit/Receive Descriptor Ring Pointer Manager

This block tracks where a DMA engine stands in two descriptor rings, one for transmit and one for receive. Each ring sits in its own contiguous memory region. The block is told the region's base address, the number of entries and a descriptor-size mode. It then presents the byte address of the descriptor the engine should work on next.

When the engine has fetched a descriptor, it shows the block that descriptor's ownership bit and pulses the ring's advance strobe. The pointer moves only if the controller owns the entry. Otherwise the pointer stays put and a per-ring flag reports that the ring has run dry (transmit) or filled up (receive).

The base, length and mode inputs are sampled only on a start pulse. Every start returns both rings to their first entry, so software must rebuild its own ring state before each restart.

Top module: `desc_ring_mgr`

## Requirements
- R1: While `rst` is high and on the edge after it, both indices are 0, both addresses are 0 and both status flags are 0.
- R2: A `start` pulse loads base, length and mode for both rings, sets both indices to 0 and clears both status flags on the next edge.
- R3: Each descriptor address equals the aligned base plus index times entry size. The entry size is 16 bytes when `mode32`=1 and 8 bytes when `mode32`=0.
- R4: The base address is aligned by forcing bits [3:0] to zero when `mode32`=1 and bits [2:0] to zero when `mode32`=0.
- R5: An advance with the ownership bit at 1 moves the index up by one on the next edge when it is not at the last entry.
- R6: An accepted advance at index length−1 returns the index to 0.
- R7: An advance with the ownership bit at 0 leaves the index unchanged and sets the ring's flag (`tx_empty` or `rx_full`) on the next edge. The flag stays set until an accepted advance or a start clears it.
- R8: A loaded length of 0 means 512 entries when `mode32`=1 and 128 entries when `mode32`=0. Any other length, up to 65535, is used as given.
- R9: An advance on one ring never changes the other ring's index, address or flag.
- R10: When `start` and an advance arrive in the same cycle, the start wins and the index becomes 0.
- R11: Changes on the base, length or mode inputs while `start` is low have no effect on the addresses or the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | Descriptor-size mode: 1 = 16-byte entries, 0 = 8-byte entries |
| start | input | 1 | Start pulse: load configuration and rewind both rings |
| tx_base | input | 32 | Transmit ring base address |
| tx_len | input | 16 | Transmit ring entry count (0 = mode maximum) |
| tx_adv | input | 1 | Transmit advance strobe |
| tx_own | input | 1 | Ownership bit of the current transmit descriptor (1 = controller) |
| rx_base | input | 32 | Receive ring base address |
| rx_len | input | 16 | Receive ring entry count (0 = mode maximum) |
| rx_adv | input | 1 | Receive advance strobe |
| rx_own | input | 1 | Ownership bit of the current receive descriptor (1 = controller) |
| tx_addr | output | 32 | Address of the current transmit descriptor |
| tx_idx | output | 16 | Current transmit entry index |
| tx_empty | output | 1 | Last transmit advance was refused because the host owns the entry |
| rx_addr | output | 32 | Address of the current receive descriptor |
| rx_idx | output | 16 | Current receive entry index |
| rx_full | output | 1 | Last receive advance was refused because the host owns the entry |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that the ownership bit is valid in any cycle in which its advance strobe is high. The configuration registers change only on `start`, so the wrap assertions take the loaded length as fixed between starts. The stimulus drives the strobes for exactly one cycle at a time and sets the ownership bit together with its strobe. It also changes base and length only while `start` is low when it is probing that they are ignored.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 16;
    localparam int NUM_RINGS  = 2;
    localparam int MAX_LEN_16 = 128;
    localparam int MAX_LEN_32 = 512;
    localparam int SHIFT_16   = 3;
    localparam int SHIFT_32   = 4;
    localparam int SHIFT_W    = 3;

    typedef enum logic {
        DSZ_WORD  = 1'b0,
        DSZ_DWORD = 1'b1
    } dsz_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        dsz_e              dsz;
    } ring_cfg_t;

    function automatic logic [SHIFT_W-1:0] entry_shift(input dsz_e dsz);
        return (dsz == DSZ_DWORD) ? SHIFT_W'(SHIFT_32) : SHIFT_W'(SHIFT_16);
    endfunction

    function automatic logic [ADDR_W-1:0] align_base(input logic [ADDR_W-1:0] b,
                                                     input dsz_e dsz);
        logic [ADDR_W-1:0] mask;
        mask = ~((ADDR_W'(1) << entry_shift(dsz)) - ADDR_W'(1));
        return b & mask;
    endfunction

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l,
                                                 input dsz_e dsz);
        if (l != '0) return l;
        return (dsz == DSZ_DWORD) ? LEN_W'(MAX_LEN_32) : LEN_W'(MAX_LEN_16);
    endfunction

endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
    import ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ring_cfg_t         cfg_in,
    output logic [ADDR_W-1:0] base_al,
    output logic [LEN_W-1:0]  len_eff,
    output logic [SHIFT_W-1:0] shift
);
    ring_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{base: '0, len: '0, dsz: DSZ_WORD};
        end else if (start) begin
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        base_al = align_base(cfg_q.base, cfg_q.dsz);
        len_eff = eff_len(cfg_q.len, cfg_q.dsz);
        shift   = entry_shift(cfg_q.dsz);
    end

    // R4
    align_chk: assert property (@(posedge clk) disable iff (rst)
        (shift == SHIFT_W'(SHIFT_32)) ? (base_al[3:0] == 4'd0) : (base_al[2:0] == 3'd0));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(base_al) && $stable(len_eff) && $stable(shift));

endmodule

// File: rtl/ring_index.sv
module ring_index
    import ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv,
    input  logic             own,
    input  logic [LEN_W-1:0] len_eff,
    output logic [LEN_W-1:0] idx,
    output logic             stall
);
    logic             at_last;
    logic [LEN_W-1:0] idx_next;

    always_comb begin
        at_last  = (idx == len_eff - 1'b1);
        idx_next = at_last ? '0 : idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            stall <= 1'b0;
        end else if (start) begin
            idx   <= '0;
            stall <= 1'b0;
        end else if (adv) begin
            if (own) begin
                idx   <= idx_next;
                stall <= 1'b0;
            end else begin
                stall <= 1'b1;
            end
        end
    end

    // R5
    adv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && own && !start && (idx != len_eff - 1'b1)) |=> (idx == $past(idx) + 1'b1));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && own && !start && (idx == len_eff - 1'b1)) |=> (idx == '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !own && !start) |=> ($stable(idx) && stall));

    // R10
    start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (idx == '0) && !stall);

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx < len_eff);

endmodule

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr
    import ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode32,
    input  logic              start,
    input  logic [ADDR_W-1:0] tx_base,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_adv,
    input  logic              tx_own,
    input  logic [ADDR_W-1:0] rx_base,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_adv,
    input  logic              rx_own,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [LEN_W-1:0]  tx_idx,
    output logic              tx_empty,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [LEN_W-1:0]  rx_idx,
    output logic              rx_full
);
    localparam int TX = 0;
    localparam int RX = 1;

    ring_cfg_t                       cfg_v   [NUM_RINGS];
    logic [NUM_RINGS-1:0]            adv_v;
    logic [NUM_RINGS-1:0]            own_v;
    logic [NUM_RINGS-1:0]            stall_v;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] base_v;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_RINGS-1:0][LEN_W-1:0]  len_v;
    logic [NUM_RINGS-1:0][LEN_W-1:0]  idx_v;
    logic [NUM_RINGS-1:0][SHIFT_W-1:0] shift_v;

    always_comb begin
        cfg_v[TX] = '{base: tx_base, len: tx_len, dsz: dsz_e'(mode32)};
        cfg_v[RX] = '{base: rx_base, len: rx_len, dsz: dsz_e'(mode32)};
        adv_v     = {rx_adv, tx_adv};
        own_v     = {rx_own, tx_own};
    end

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        ring_cfg u_cfg (
            .clk     (clk),
            .rst     (rst),
            .start   (start),
            .cfg_in  (cfg_v[g]),
            .base_al (base_v[g]),
            .len_eff (len_v[g]),
            .shift   (shift_v[g])
        );

        ring_index u_idx (
            .clk     (clk),
            .rst     (rst),
            .start   (start),
            .adv     (adv_v[g]),
            .own     (own_v[g]),
            .len_eff (len_v[g]),
            .idx     (idx_v[g]),
            .stall   (stall_v[g])
        );

        always_comb addr_v[g] = base_v[g] + (ADDR_W'(idx_v[g]) << shift_v[g]);
    end

    assign tx_addr  = addr_v[TX];
    assign tx_idx   = idx_v[TX];
    assign tx_empty = stall_v[TX];
    assign rx_addr  = addr_v[RX];
    assign rx_idx   = idx_v[RX];
    assign rx_full  = stall_v[RX];

    // R9
    rx_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_adv && !rx_adv && !start) |=> $stable(rx_idx) && $stable(rx_full));

    // R9
    tx_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_adv && !tx_adv && !start) |=> $stable(tx_idx) && $stable(tx_empty));

endmodule

// File: tb/test_desc_ring_mgr.sv
module test_desc_ring_mgr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode32 = 1'b0, start = 1'b0;
    logic [31:0] tx_base = '0, rx_base = '0;
    logic [15:0] tx_len = '0, rx_len = '0;
    logic        tx_adv = 1'b0, tx_own = 1'b0, rx_adv = 1'b0, rx_own = 1'b0;
    logic [31:0] tx_addr, rx_addr;
    logic [15:0] tx_idx, rx_idx;
    logic        tx_empty, rx_full;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    desc_ring_mgr i_desc_ring_mgr (.*);

    // Table for transmit ring: len 3, 16-byte entries, base 0x1000 after alignment
    localparam int  N = 8;
    localparam bit  T_ADV  [N] = '{1, 1, 1, 1, 0, 1, 1, 1};
    localparam bit  T_OWN  [N] = '{1, 1, 1, 0, 0, 1, 0, 1};
    localparam int  T_IDX  [N] = '{1, 2, 0, 0, 0, 1, 1, 2};
    localparam bit  T_FLAG [N] = '{0, 0, 0, 1, 1, 0, 1, 0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ta, input logic to, input logic ra, input logic ro,
                       input logic st);
        @(negedge clk);
        tx_adv = ta; tx_own = to; rx_adv = ra; rx_own = ro; start = st;
        @(posedge clk);
        #1;
        tx_adv = 1'b0; rx_adv = 1'b0; start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 tx_idx in reset", 32'(tx_idx), 0);
        chk("R1 rx_addr in reset", rx_addr, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 tx_addr after reset", tx_addr, 0);
        chk("R1 flags after reset", {30'd0, tx_empty, rx_full}, 0);

        // R2 / R4 start in 32-bit mode with unaligned bases
        mode32 = 1'b1; tx_base = 32'h0000_1003; tx_len = 16'd3;
        rx_base = 32'h8000_000F; rx_len = 16'd5;
        cyc(0, 0, 0, 0, 1);
        chk("R4 tx base aligned to 16", tx_addr, 32'h0000_1000);
        chk("R4 rx base aligned to 16", rx_addr, 32'h8000_0000);
        chk("R2 tx_idx after start", 32'(tx_idx), 0);

        // Table walk on transmit ring (R3, R5, R6, R7, R9)
        for (int i = 0; i < N; i++) begin
            cyc(T_ADV[i], T_OWN[i], 0, 0, 0);
            chk($sformatf("R5/R6 tx_idx step %0d", i), 32'(tx_idx), T_IDX[i]);
            chk($sformatf("R7 tx_empty step %0d", i), 32'(tx_empty), 32'(T_FLAG[i]));
            chk($sformatf("R3 tx_addr step %0d", i), tx_addr, 32'h1000 + T_IDX[i] * 16);
            chk($sformatf("R9 rx_idx step %0d", i), 32'(rx_idx), 0);
        end

        // R7 on receive ring, R9 transmit untouched
        cyc(0, 0, 1, 0, 0);
        chk("R7 rx_full set", 32'(rx_full), 1);
        chk("R7 rx_idx held", 32'(rx_idx), 0);
        chk("R9 tx_idx untouched by rx", 32'(tx_idx), 2);
        cyc(0, 0, 1, 1, 0);
        chk("R7 rx_full cleared by accepted advance", 32'(rx_full), 0);
        chk("R5 rx_idx stepped", 32'(rx_idx), 1);
        chk("R3 rx_addr", rx_addr, 32'h8000_0010);

        // R11: config inputs change without start
        tx_base = 32'h0000_5000; tx_len = 16'd1; mode32 = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk("R11 tx_addr unchanged", tx_addr, 32'h0000_1020);
        cyc(1, 1, 0, 0, 0);
        chk("R11 wrap point from loaded length", 32'(tx_idx), 0);
        cyc(1, 1, 0, 0, 0);
        chk("R11 idx 1 still allowed", 32'(tx_idx), 1);
        chk("R11 addr uses loaded mode", tx_addr, 32'h0000_1010);

        // R10: start with simultaneous advance, switch to 16-bit mode, len 0
        cyc(0, 0, 1, 0, 0);
        tx_base = 32'h0000_2005; tx_len = 16'd0; rx_base = 32'h0000_3000; rx_len = 16'd2;
        cyc(1, 1, 1, 1, 1);
        chk("R10 tx_idx zero on start+adv", 32'(tx_idx), 0);
        chk("R2 rx_full cleared by start", 32'(rx_full), 0);
        chk("R4 base aligned to 8", tx_addr, 32'h0000_2000);

        cyc(1, 1, 0, 0, 0);
        chk("R3 8-byte entry", tx_addr, 32'h0000_2008);
        for (int i = 0; i < 126; i++) cyc(1, 1, 0, 0, 0);
        chk("R8 16-bit len0 last idx", 32'(tx_idx), 127);
        chk("R3 16-bit last addr", tx_addr, 32'h2000 + 127 * 8);
        cyc(1, 1, 0, 0, 0);
        chk("R8 16-bit len0 wraps at 128", 32'(tx_idx), 0);

        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 1, 1, 0);
        chk("R6 rx wraps at len 2", 32'(rx_idx), 0);

        // R8 32-bit len 0
        mode32 = 1'b1; tx_base = 32'h0000_4000; tx_len = 16'd0;
        cyc(0, 0, 0, 0, 1);
        for (int i = 0; i < 511; i++) cyc(1, 1, 0, 0, 0);
        chk("R8 32-bit len0 last idx", 32'(tx_idx), 511);
        chk("R3 32-bit last addr", tx_addr, 32'h0000_5FF0);
        cyc(1, 1, 0, 0, 0);
        chk("R8 32-bit len0 wraps at 512", 32'(tx_idx), 0);

        // R8 large directly given length
        tx_len = 16'd65535;
        cyc(0, 0, 0, 0, 1);
        for (int i = 0; i < 600; i++) cyc(1, 1, 0, 0, 0);
        chk("R8 length 65535 passes 512", 32'(tx_idx), 600);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule